// File: doc/BRIEF.md
# Host Task File Register Decoder

This block is the device-side register bank for a parallel disk attachment port. It decodes the host's two active-low chip selects and its 3-bit register address. It accepts host writes into the command parameter registers and the device control register. On host reads it selects the value to return and drives per-bit output enables so the bus is driven only when a register is actually being read.

The drive core receives three things from the block. It gets the stored parameter bytes and the last command code, with a one-cycle strobe when that code is written. It gets the soft-reset and interrupt-enable controls. It also gets a registered word and strobe for each host write to the data port. The core supplies the live status byte, the error byte, the word to present on data port reads, and a write-gate flag; the block uses these on reads.

Host writes are taken on the falling edge of the write strobe, as sampled by the block clock. Host reads are combinational from the address and the read strobe.

Top module: `taskfile_regbank`

## Requirements
- R1: After reset, every parameter register and the command code are 00h, except the drive/head register, which is A0h. Soft reset is 0, interrupt enable is 1, and both strobes are low.
- R2: On a write with only the command chip select asserted, addresses 1 to 6 load features, sector count, sector number, cylinder low, cylinder high and drive/head from the low data byte. Drive/head bits 7 and 5 always read 1. Only one register update happens for each falling edge of the write strobe.
- R3: A write to command-select address 7 loads the command code and raises the command strobe for exactly one cycle, in the cycle after the clock edge that saw the write strobe fall. A write to address 0 presents the 16-bit word and raises the data-write strobe for one cycle with the same timing.
- R4: While status bit 7 (busy) is 1, writes to command-select addresses 0 to 7 change no register and raise no strobe.
- R5: A write to control-select address 6 is always accepted, even while busy. Data bit 2 sets the soft-reset output, and data bit 1 set to 1 turns the interrupt-enable output off.
- R6: Reads with only the command chip select asserted and busy clear return the following. Address 0 returns the data word with all 16 bits driven. Address 1 returns the error byte, addresses 2 to 6 return the stored registers, and address 7 returns status. For addresses 1 to 7 only bits 7 to 0 are driven.
- R7: While busy, a read of any command-select address returns the status byte on bits 7 to 0, and bits 15 to 8 are not driven.
- R8: Reads with only the control chip select asserted work as follows. Address 6 returns status. Address 7 returns the drive-address byte: bit 7 undriven, bit 6 the inverse of write-gate, bits 5 to 2 the inverted head field, bit 1 low when drive/head bit 4 is 1, bit 0 low when it is 0. Every other address drives nothing, and writes to those addresses change nothing.
- R9: With both chip selects negated, or both asserted, reads drive nothing and writes change nothing.
- R10: While the read strobe is high, no bit of the data bus is driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_cmd_n | input | 1 | Chip select for the command register group, active low |
| cs_ctl_n | input | 1 | Chip select for the control register group, active low |
| addr | input | 3 | Register address from host |
| rd_n | input | 1 | Host read strobe, active low |
| wr_n | input | 1 | Host write strobe, active low |
| wdata | input | 16 | Host write data |
| status_in | input | 8 | Live status byte from the drive core, bit 7 = busy |
| error_in | input | 8 | Error byte from the drive core |
| data_in | input | 16 | Word returned on data port reads |
| wgate_active | input | 1 | Write gate currently on |
| rdata | output | 16 | Read data toward the host bus |
| rdata_oe | output | 16 | Per-bit output enable for rdata |
| features | output | 8 | Features register |
| sect_cnt | output | 8 | Sector count register |
| sect_num | output | 8 | Sector number register |
| cyl_lo | output | 8 | Cylinder low register |
| cyl_hi | output | 8 | Cylinder high register |
| drv_head | output | 8 | Drive/head register |
| cmd_code | output | 8 | Last accepted command code |
| cmd_stb | output | 1 | One-cycle pulse on command write |
| data_wr_stb | output | 1 | One-cycle pulse on data port write |
| data_wr_word | output | 16 | Word captured on data port write |
| soft_reset | output | 1 | Soft-reset control from device control |
| irq_enable | output | 1 | Interrupt enable (inverse of the stored disable bit) |

## Verification
The bench goes after the busy window. A design that ignores busy on writes would overwrite the sector count or fire a command strobe. A design that applies busy to the control group would lose a soft-reset request. The bench checks that a write strobe held low for several cycles gives exactly one update and a single-cycle command strobe; a level-sensitive design would repeat the pulse. It also drives both chip selects asserted and both negated during reads and writes, and reads unused control addresses. A decoder that falls through to a default register would then drive the bus or corrupt state. Finally, it reads the drive-address byte with each drive number and head value, so a missing inversion or an enabled bit 7 shows up at once.

// File: rtl/tfr_pkg.sv
package tfr_pkg;
    localparam int HOST_DW = 16;
    localparam int REG_W   = 8;
    localparam int ADDR_W  = 3;
    localparam int BUSY_BIT = REG_W - 1;
    localparam logic [REG_W-1:0] DH_FIXED = 8'hA0;

    typedef enum logic [3:0] {
        RS_NONE, RS_DATA, RS_ERR, RS_CNT, RS_SNUM, RS_CLO,
        RS_CHI, RS_DH, RS_STAT, RS_ALT, RS_DADDR
    } rd_sel_e;

    typedef enum logic [3:0] {
        WS_NONE, WS_DATA, WS_FEAT, WS_CNT, WS_SNUM, WS_CLO,
        WS_CHI, WS_DH, WS_CMD, WS_DCTL
    } wr_sel_e;

    typedef struct packed {
        logic [REG_W-1:0] feat;
        logic [REG_W-1:0] cnt;
        logic [REG_W-1:0] snum;
        logic [REG_W-1:0] clo;
        logic [REG_W-1:0] chi;
        logic [REG_W-1:0] dh;
        logic [REG_W-1:0] cmd;
        logic             srst;
        logic             nien;
    } tf_regs_t;

    typedef struct packed {
        tf_regs_t           r;
        logic               wr_n_prev;
        logic               cmd_stb;
        logic               data_stb;
        logic [HOST_DW-1:0] data_word;
    } bank_state_t;
endpackage

// File: rtl/tfr_decode.sv
module tfr_decode
    import tfr_pkg::*;
(
    input  logic              cs_cmd_n,
    input  logic              cs_ctl_n,
    input  logic [ADDR_W-1:0] addr,
    output rd_sel_e           rd_sel,
    output wr_sel_e           wr_sel
);
    always_comb begin
        rd_sel = RS_NONE;
        wr_sel = WS_NONE;
        if (!cs_cmd_n && cs_ctl_n) begin
            unique case (addr)
                3'd0: begin rd_sel = RS_DATA; wr_sel = WS_DATA; end
                3'd1: begin rd_sel = RS_ERR;  wr_sel = WS_FEAT; end
                3'd2: begin rd_sel = RS_CNT;  wr_sel = WS_CNT;  end
                3'd3: begin rd_sel = RS_SNUM; wr_sel = WS_SNUM; end
                3'd4: begin rd_sel = RS_CLO;  wr_sel = WS_CLO;  end
                3'd5: begin rd_sel = RS_CHI;  wr_sel = WS_CHI;  end
                3'd6: begin rd_sel = RS_DH;   wr_sel = WS_DH;   end
                default: begin rd_sel = RS_STAT; wr_sel = WS_CMD; end
            endcase
        end else if (cs_cmd_n && !cs_ctl_n) begin
            if (addr == 3'd6) begin
                rd_sel = RS_ALT;
                wr_sel = WS_DCTL;
            end else if (addr == 3'd7) begin
                rd_sel = RS_DADDR;
            end
        end
    end
endmodule

// File: rtl/tfr_regs.sv
module tfr_regs
    import tfr_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_n,
    input  wr_sel_e            wr_sel,
    input  logic               busy,
    input  logic [HOST_DW-1:0] wdata,
    output tf_regs_t           regs,
    output logic               cmd_stb,
    output logic               data_stb,
    output logic [HOST_DW-1:0] data_word
);
    bank_state_t st_d, st_q;
    logic wr_edge;
    logic take_cb;
    logic [REG_W-1:0] wbyte;

    always_comb begin
        st_d          = st_q;
        wr_edge       = st_q.wr_n_prev & ~wr_n;
        take_cb       = wr_edge & ~busy;
        wbyte         = wdata[REG_W-1:0];
        st_d.wr_n_prev = wr_n;
        st_d.cmd_stb  = 1'b0;
        st_d.data_stb = 1'b0;
        if (take_cb) begin
            case (wr_sel)
                WS_DATA: begin
                    st_d.data_stb  = 1'b1;
                    st_d.data_word = wdata;
                end
                WS_FEAT: st_d.r.feat = wbyte;
                WS_CNT:  st_d.r.cnt  = wbyte;
                WS_SNUM: st_d.r.snum = wbyte;
                WS_CLO:  st_d.r.clo  = wbyte;
                WS_CHI:  st_d.r.chi  = wbyte;
                WS_DH:   st_d.r.dh   = wbyte | DH_FIXED;
                WS_CMD: begin
                    st_d.r.cmd   = wbyte;
                    st_d.cmd_stb = 1'b1;
                end
                default: ;
            endcase
        end
        if (wr_edge && wr_sel == WS_DCTL) begin
            st_d.r.srst = wdata[2];
            st_d.r.nien = wdata[1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q           <= '0;
            st_q.r.dh      <= DH_FIXED;
            st_q.wr_n_prev <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign regs      = st_q.r;
    assign cmd_stb   = st_q.cmd_stb;
    assign data_stb  = st_q.data_stb;
    assign data_word = st_q.data_word;

    p_cmd_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_stb |=> !cmd_stb);
    p_busy_nocmd_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && wr_edge && wr_sel == WS_CMD) |=> (!cmd_stb && $stable(regs.cmd)));
    p_dh_fixed_r2: assert property (@(posedge clk) disable iff (!rst_n)
        regs.dh[7] && regs.dh[5]);
    p_dctl_any_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_edge && wr_sel == WS_DCTL) |=> (regs.srst == $past(wdata[2])));
endmodule

// File: rtl/tfr_readmux.sv
module tfr_readmux
    import tfr_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rd_n,
    input  rd_sel_e            rd_sel,
    input  tf_regs_t           regs,
    input  logic [REG_W-1:0]   status_in,
    input  logic [REG_W-1:0]   error_in,
    input  logic [HOST_DW-1:0] data_in,
    input  logic               wgate_active,
    output logic [HOST_DW-1:0] rdata,
    output logic [HOST_DW-1:0] rdata_oe
);
    localparam int HI_W = HOST_DW - REG_W;

    logic busy;
    logic cmd_group;
    logic [REG_W-1:0] daddr;
    logic [REG_W-1:0] lo_byte;
    logic lo_en, hi_en, b7_off;

    assign busy      = status_in[BUSY_BIT];
    assign cmd_group = (rd_sel inside {RS_DATA, RS_ERR, RS_CNT, RS_SNUM,
                                       RS_CLO, RS_CHI, RS_DH, RS_STAT});
    assign daddr     = {1'b0, ~wgate_active, ~regs.dh[3:0], ~regs.dh[4], regs.dh[4]};

    always_comb begin
        lo_byte = '0;
        lo_en   = 1'b0;
        hi_en   = 1'b0;
        b7_off  = 1'b0;
        rdata   = '0;
        if (!rd_n) begin
            if (cmd_group && busy) begin
                lo_byte = status_in;
                lo_en   = 1'b1;
            end else begin
                case (rd_sel)
                    RS_DATA: begin
                        rdata = data_in;
                        lo_byte = data_in[REG_W-1:0];
                        lo_en = 1'b1;
                        hi_en = 1'b1;
                    end
                    RS_ERR:  begin lo_byte = error_in;  lo_en = 1'b1; end
                    RS_CNT:  begin lo_byte = regs.cnt;  lo_en = 1'b1; end
                    RS_SNUM: begin lo_byte = regs.snum; lo_en = 1'b1; end
                    RS_CLO:  begin lo_byte = regs.clo;  lo_en = 1'b1; end
                    RS_CHI:  begin lo_byte = regs.chi;  lo_en = 1'b1; end
                    RS_DH:   begin lo_byte = regs.dh;   lo_en = 1'b1; end
                    RS_STAT, RS_ALT: begin lo_byte = status_in; lo_en = 1'b1; end
                    RS_DADDR: begin lo_byte = daddr; lo_en = 1'b1; b7_off = 1'b1; end
                    default: ;
                endcase
            end
        end
        rdata[REG_W-1:0] = lo_byte;
        rdata_oe = {{HI_W{hi_en}}, lo_en & ~b7_off, {(REG_W-1){lo_en}}};
    end

    p_idle_float_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rd_n |-> (rdata_oe == '0));
    p_hi_only_data_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (|rdata_oe[HOST_DW-1:REG_W]) |-> (rd_sel == RS_DATA && !busy));
    p_daddr_b7_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_sel == RS_DADDR) |-> !rdata_oe[REG_W-1]);
    p_busy_status_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_n && cmd_group && busy) |-> (rdata[REG_W-1:0] == status_in));
endmodule

// File: rtl/taskfile_regbank.sv
module taskfile_regbank
    import tfr_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cs_cmd_n,
    input  logic               cs_ctl_n,
    input  logic [ADDR_W-1:0]  addr,
    input  logic               rd_n,
    input  logic               wr_n,
    input  logic [HOST_DW-1:0] wdata,
    input  logic [REG_W-1:0]   status_in,
    input  logic [REG_W-1:0]   error_in,
    input  logic [HOST_DW-1:0] data_in,
    input  logic               wgate_active,
    output logic [HOST_DW-1:0] rdata,
    output logic [HOST_DW-1:0] rdata_oe,
    output logic [REG_W-1:0]   features,
    output logic [REG_W-1:0]   sect_cnt,
    output logic [REG_W-1:0]   sect_num,
    output logic [REG_W-1:0]   cyl_lo,
    output logic [REG_W-1:0]   cyl_hi,
    output logic [REG_W-1:0]   drv_head,
    output logic [REG_W-1:0]   cmd_code,
    output logic               cmd_stb,
    output logic               data_wr_stb,
    output logic [HOST_DW-1:0] data_wr_word,
    output logic               soft_reset,
    output logic               irq_enable
);
    rd_sel_e  rd_sel;
    wr_sel_e  wr_sel;
    tf_regs_t regs;

    tfr_decode u_decode (
        .cs_cmd_n (cs_cmd_n),
        .cs_ctl_n (cs_ctl_n),
        .addr     (addr),
        .rd_sel   (rd_sel),
        .wr_sel   (wr_sel)
    );

    tfr_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_n      (wr_n),
        .wr_sel    (wr_sel),
        .busy      (status_in[BUSY_BIT]),
        .wdata     (wdata),
        .regs      (regs),
        .cmd_stb   (cmd_stb),
        .data_stb  (data_wr_stb),
        .data_word (data_wr_word)
    );

    tfr_readmux u_readmux (
        .clk          (clk),
        .rst_n        (rst_n),
        .rd_n         (rd_n),
        .rd_sel       (rd_sel),
        .regs         (regs),
        .status_in    (status_in),
        .error_in     (error_in),
        .data_in      (data_in),
        .wgate_active (wgate_active),
        .rdata        (rdata),
        .rdata_oe     (rdata_oe)
    );

    assign features   = regs.feat;
    assign sect_cnt   = regs.cnt;
    assign sect_num   = regs.snum;
    assign cyl_lo     = regs.clo;
    assign cyl_hi     = regs.chi;
    assign drv_head   = regs.dh;
    assign cmd_code   = regs.cmd;
    assign soft_reset = regs.srst;
    assign irq_enable = ~regs.nien;

    p_bad_cs_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_cmd_n == cs_ctl_n) |-> (rd_sel == RS_NONE && wr_sel == WS_NONE));
    p_ctl_nowrite_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_cmd_n && !cs_ctl_n && addr != 3'd6) |-> (wr_sel == WS_NONE));
endmodule

// File: tb/test_taskfile_regbank.sv
module test_taskfile_regbank;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_cmd_n = 1'b1, cs_ctl_n = 1'b1;
    logic [2:0]  addr = '0;
    logic        rd_n = 1'b1, wr_n = 1'b1;
    logic [15:0] wdata = '0;
    logic [7:0]  status_in = 8'h50, error_in = 8'h01;
    logic [15:0] data_in = 16'hBEEF;
    logic        wgate_active = 1'b0;
    logic [15:0] rdata, rdata_oe;
    logic [7:0]  features, sect_cnt, sect_num, cyl_lo, cyl_hi, drv_head, cmd_code;
    logic        cmd_stb, data_wr_stb, soft_reset, irq_enable;
    logic [15:0] data_wr_word;

    int total = 0;
    int bad = 0;
    bit done = 0;

    taskfile_regbank i_taskfile_regbank (
        .clk(clk), .rst_n(rst_n), .cs_cmd_n(cs_cmd_n), .cs_ctl_n(cs_ctl_n),
        .addr(addr), .rd_n(rd_n), .wr_n(wr_n), .wdata(wdata),
        .status_in(status_in), .error_in(error_in), .data_in(data_in),
        .wgate_active(wgate_active), .rdata(rdata), .rdata_oe(rdata_oe),
        .features(features), .sect_cnt(sect_cnt), .sect_num(sect_num),
        .cyl_lo(cyl_lo), .cyl_hi(cyl_hi), .drv_head(drv_head),
        .cmd_code(cmd_code), .cmd_stb(cmd_stb), .data_wr_stb(data_wr_stb),
        .data_wr_word(data_wr_word), .soft_reset(soft_reset),
        .irq_enable(irq_enable)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // reference model state: index 1..6 parameter bytes, 7 command code
    int m_reg [0:7];
    bit m_prev_wr, m_cmd_stb, m_data_stb, m_srst, m_nien;
    int m_data_word;

    task automatic check(input bit ok, input string what, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < 8; i++) m_reg[i] <= 0;
            m_reg[6] <= 'hA0;
            m_prev_wr <= 1; m_cmd_stb <= 0; m_data_stb <= 0;
            m_srst <= 0; m_nien <= 0; m_data_word <= 0;
        end else begin
            m_prev_wr <= wr_n;
            m_cmd_stb <= 0;
            m_data_stb <= 0;
            if (m_prev_wr && !wr_n) begin
                if (!cs_cmd_n && cs_ctl_n && !status_in[7]) begin
                    if (addr == 0) begin
                        m_data_stb <= 1;
                        m_data_word <= int'(wdata);
                    end else if (addr == 6) begin
                        m_reg[6] <= int'(wdata[7:0]) | 'hA0;
                    end else begin
                        m_reg[addr] <= int'(wdata[7:0]);
                        if (addr == 7) m_cmd_stb <= 1;
                    end
                end
                if (cs_cmd_n && !cs_ctl_n && addr == 6) begin
                    m_srst <= wdata[2];
                    m_nien <= wdata[1];
                end
            end
        end
    end

    // expected read: returns tag of the requirement that governs the case
    task automatic exp_read(output int d, output int oe, output string tag);
        int dh;
        dh = m_reg[6];
        d = 0; oe = 0;
        if (rd_n) begin
            tag = "R10";
        end else if (cs_cmd_n == cs_ctl_n) begin
            tag = "R9";
        end else if (!cs_cmd_n) begin
            if (status_in[7]) begin
                tag = "R7"; d = status_in; oe = 'h00FF;
            end else begin
                tag = "R6"; oe = 'h00FF;
                case (addr)
                    0: begin d = data_in; oe = 'hFFFF; end
                    1: d = error_in;
                    7: d = status_in;
                    default: d = m_reg[addr];
                endcase
            end
        end else begin
            tag = "R8";
            if (addr == 6) begin
                d = status_in; oe = 'h00FF;
            end else if (addr == 7) begin
                oe = 'h007F;
                d = ((wgate_active ? 0 : 1) << 6) | (((~dh) & 'hF) << 2)
                    | (((dh >> 4) & 1) ? 'h1 : 'h2);
            end
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            int ed, eo;
            string tg;
            exp_read(ed, eo, tg);
            check(int'(rdata_oe) == eo, {tg, " read enable"}, rdata_oe, eo);
            check((int'(rdata) & eo) == ed, {tg, " read data"}, int'(rdata) & eo, ed);
            check(features == m_reg[1][7:0] && sect_cnt == m_reg[2][7:0]
                  && sect_num == m_reg[3][7:0], "R2 regs a", {features, sect_cnt, sect_num},
                  {m_reg[1][7:0], m_reg[2][7:0], m_reg[3][7:0]});
            check(cyl_lo == m_reg[4][7:0] && cyl_hi == m_reg[5][7:0] && drv_head == m_reg[6][7:0],
                  "R2 regs b", {cyl_lo, cyl_hi, drv_head},
                  {m_reg[4][7:0], m_reg[5][7:0], m_reg[6][7:0]});
            check(cmd_code == m_reg[7][7:0] && cmd_stb == m_cmd_stb, "R3 command",
                  {cmd_code, 7'd0, cmd_stb}, {m_reg[7][7:0], 7'd0, m_cmd_stb});
            check(data_wr_stb == m_data_stb && (!m_data_stb || data_wr_word == m_data_word[15:0]),
                  "R3 data write", {data_wr_stb, data_wr_word}, {m_data_stb, m_data_word[15:0]});
            check(soft_reset == m_srst && irq_enable == !m_nien, "R5 control",
                  {soft_reset, irq_enable}, {m_srst, !m_nien});
        end
    end

    task automatic host_write(input bit cmdsel, input bit ctlsel, input int a, input int v, input int hold);
        @(posedge clk); #1;
        cs_cmd_n = !cmdsel; cs_ctl_n = !ctlsel; addr = a[2:0]; wdata = v[15:0]; wr_n = 0;
        repeat (hold) @(posedge clk);
        #1 wr_n = 1;
        @(posedge clk); #1;
        cs_cmd_n = 1; cs_ctl_n = 1;
    endtask

    task automatic host_read(input bit cmdsel, input bit ctlsel, input int a);
        @(posedge clk); #1;
        cs_cmd_n = !cmdsel; cs_ctl_n = !ctlsel; addr = a[2:0]; rd_n = 0;
        repeat (2) @(posedge clk);
        #1 rd_n = 1; cs_cmd_n = 1; cs_ctl_n = 1;
    endtask

    int cmd_pulses = 0;
    always @(negedge clk) if (rst_n && cmd_stb) cmd_pulses++;

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        check(drv_head == 8'hA0 && sect_cnt == 0 && cmd_code == 0, "R1 reset regs", drv_head, 'hA0);
        check(irq_enable == 1 && soft_reset == 0 && !cmd_stb && !data_wr_stb, "R1 reset ctrl",
              {irq_enable, soft_reset}, 2'b10);
        rst_n = 1;
        repeat (2) @(posedge clk);

        host_write(1, 0, 1, 'h11, 1);
        host_write(1, 0, 2, 'h22, 1);
        host_write(1, 0, 3, 'h33, 1);
        host_write(1, 0, 4, 'h44, 1);
        host_write(1, 0, 5, 'h55, 1);
        host_write(1, 0, 6, 'h5F, 1);
        #1 check(drv_head == 8'hFF, "R2 drive/head fixed bits", drv_head, 'hFF);
        for (int a = 0; a < 8; a++) host_read(1, 0, a);

        // long-held write strobe: one command pulse
        cmd_pulses = 0;
        host_write(1, 0, 7, 'h20, 5);
        repeat (2) @(posedge clk);
        #1 check(cmd_pulses == 1 && cmd_code == 8'h20, "R3 single pulse", cmd_pulses, 1);
        host_write(1, 0, 0, 'hA5C3, 3);

        // busy window
        status_in = 8'hD0;
        cmd_pulses = 0;
        host_write(1, 0, 2, 'h99, 1);
        host_write(1, 0, 7, 'hEC, 1);
        host_write(1, 0, 0, 'h1234, 1);
        #1 check(sect_cnt == 8'h22 && cmd_pulses == 0 && cmd_code == 8'h20, "R4 busy blocks",
                 sect_cnt, 'h22);
        host_write(0, 1, 6, 'h06, 1);
        #1 check(soft_reset && !irq_enable, "R5 control while busy", {soft_reset, irq_enable}, 2'b10);
        for (int a = 0; a < 8; a++) host_read(1, 0, a);
        host_read(0, 1, 6);
        status_in = 8'h50;
        host_write(0, 1, 6, 'h00, 1);

        // control group reads, drive address with both drive numbers
        wgate_active = 1;
        host_read(0, 1, 7);
        host_write(1, 0, 6, 'h03, 1);
        wgate_active = 0;
        for (int a = 0; a < 8; a++) host_read(0, 1, a);
        host_write(0, 1, 3, 'h06, 1);
        host_write(0, 1, 7, 'h04, 1);
        #1 check(!soft_reset && irq_enable, "R8 unused control writes", soft_reset, 0);

        // invalid / idle selects
        host_write(1, 1, 2, 'h77, 1);
        host_write(0, 0, 2, 'h66, 1);
        host_write(1, 1, 6, 'h04, 1);
        #1 check(sect_cnt == 8'h22 && !soft_reset, "R9 bad selects ignored", sect_cnt, 'h22);
        host_read(1, 1, 2);
        host_read(0, 0, 6);
        @(posedge clk); #1 cs_cmd_n = 0; addr = 3'd2;
        @(negedge clk) check(rdata_oe == 0, "R10 no read strobe", rdata_oe, 0);
        #1 cs_cmd_n = 1;
        repeat (3) @(posedge clk);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        bad++; total++;
        $display("FAIL watchdog actual=running expected=finished");
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule